// File: doc/BRIEF.md
# PWM Prescaler Tick Generator

This block produces the common set of timing strobes that drive the channels of a multi-channel PWM unit. Everything runs from one master clock. A free-running binary counter yields eleven prescaled strobes, one for each master clock divided by a power of two from 1 to 1024. Each strobe is a one-cycle enable pulse in the master clock domain; none of them is a derived clock. Two linear dividers sit on top of that ladder. Each divider picks one rung and divides it again by a programmable 8-bit factor. The result is thirteen selectable strobes that all PWM channels share.

Configuration uses a single write port. One write sets the source and the factor of one divider. A factor of zero, or a source code that names no rung, silences that divider. A write restarts the divider's count, so the first strobe after a change comes only after a full new period.

Top module: `pwm_tick_gen`

## Requirements
- R1: While `rst` is high, `tick_pre` and `tick_lin` are all zero. After reset each divider has source 0 and factor 0, so it is silent until it is written.
- R2: Let t be the number of rising edges since `rst` fell, with t = 0 in the first cycle after reset. Then `tick_pre[k]` is high exactly when (t+1) is a multiple of 2^k, for k = 0..10. This means `tick_pre[0]` is high in every cycle.
- R3: `wr_en` high with `wr_idx` = i loads divider i from `wr_src` (4 bits) and `wr_div` (8 bits) at the next rising edge.
- R4: A divider with factor N (1..255) and source s (0..10) raises `tick_lin[i]` in the same cycle as the Nth, 2Nth, 3Nth, ... pulse of `tick_pre[s]`. Counting starts from the first pulse after the write.
- R5: A divider with factor 0 never raises its `tick_lin` bit.
- R6: A divider with a source code of 11..15 never raises its `tick_lin` bit.
- R7: In the cycle where divider i is being written, `tick_lin[i]` is low. Its pulse count then restarts from zero.
- R8: A write to one divider does not change the output or the count of the other divider.
- R9: Writes never disturb the prescaler counter or the `tick_pre` strobes.

Port directions and widths are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Divider configuration write strobe |
| wr_idx | input | 1 | Divider addressed by the write |
| wr_src | input | 4 | Source rung, 0..10 valid |
| wr_div | input | 8 | Divide factor, 0 = off |
| tick_pre | output | 11 | Power-of-two strobes, bit k = clock / 2^k |
| tick_lin | output | 2 | Linear divider strobes |

## Verification
The hardest case to reach from the ports is a write that lands in the very cycle when the old configuration would have fired. The same applies to a write on one divider while the other divider is about to fire. The sweep reaches these cases in three ways:
- It rewrites the two dividers alternately every few cycles.
- The sources are low rungs that pulse almost every cycle, so writes and would-be pulses are certain to collide.
- The factors are small.

The bench also holds long runs on rung 10 and with factor 255. These runs confirm the wide end of the counter and of the factor.

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_N = 11,
  parameter int LIN_N = 2,
  parameter int SEL_W = 4,
  parameter int FAC_W = 8,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_src,
  input  logic [FAC_W-1:0] wr_div,
  output logic [PRE_N-1:0] tick_pre,
  output logic [LIN_N-1:0] tick_lin
);
  localparam int CNT_W = PRE_N - 1;
  localparam int SEL_N = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [PRE_N-1:0] pre_raw;
  logic [SEL_N-1:0] pre_ext;

  always_ff @(posedge clk)
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;

  assign pre_raw[0] = 1'b1;
  for (genvar k = 1; k < PRE_N; k++) begin : g_pre
    assign pre_raw[k] = &cnt[k-1:0];
  end

  assign pre_ext  = SEL_N'(pre_raw);
  assign tick_pre = rst ? '0 : pre_raw;

  logic [SEL_W-1:0] src_q [LIN_N];
  logic [FAC_W-1:0] fac_q [LIN_N];
  logic [FAC_W-1:0] cnt_q [LIN_N];

  for (genvar i = 0; i < LIN_N; i++) begin : g_lin
    logic hit_wr, src_tick, last, live;
    assign hit_wr   = wr_en && (wr_idx == IDX_W'(i));
    assign src_tick = pre_ext[src_q[i]];
    assign last     = cnt_q[i] == fac_q[i] - 1'b1;
    assign live     = fac_q[i] != '0;
    assign tick_lin[i] = !rst && !hit_wr && live && src_tick && last;

    always_ff @(posedge clk)
      if (rst) begin
        src_q[i] <= '0;
        fac_q[i] <= '0;
        cnt_q[i] <= '0;
      end else if (hit_wr) begin
        src_q[i] <= wr_src;
        fac_q[i] <= wr_div;
        cnt_q[i] <= '0;
      end else if (live && src_tick) begin
        cnt_q[i] <= last ? '0 : cnt_q[i] + 1'b1;
      end
  end
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
  parameter int PRE_N = 11,
  parameter int LIN_N = 2,
  parameter int SEL_W = 4,
  parameter int FAC_W = 8,
  parameter int IDX_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [PRE_N-1:0] tick_pre,
  input logic [LIN_N-1:0] tick_lin,
  input logic [SEL_W-1:0] src0,
  input logic [SEL_W-1:0] src1,
  input logic [FAC_W-1:0] fac0,
  input logic [FAC_W-1:0] fac1
);
  // R1
  always @(posedge clk)
    if (rst) reset_quiet_chk: assert (tick_pre == '0 && tick_lin == '0);

  // R2
  base_every_cycle_chk: assert property (@(posedge clk) disable iff (rst) tick_pre[0]);

  // R2
  ladder_nested_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_pre[PRE_N-1:1] & ~tick_pre[PRE_N-2:0]) == '0);

  // R4
  lin0_on_source_chk: assert property (@(posedge clk) disable iff (rst)
    tick_lin[0] |-> (src0 < PRE_N) && (((tick_pre >> src0) & 1) != 0));

  // R4
  lin1_on_source_chk: assert property (@(posedge clk) disable iff (rst)
    tick_lin[1] |-> (src1 < PRE_N) && (((tick_pre >> src1) & 1) != 0));

  // R5
  fac_zero_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (fac0 == '0 |-> !tick_lin[0]) and (fac1 == '0 |-> !tick_lin[1]));

  // R7
  write_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !tick_lin[wr_idx]);
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
  .PRE_N(PRE_N), .LIN_N(LIN_N), .SEL_W(SEL_W), .FAC_W(FAC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
  .tick_pre(tick_pre), .tick_lin(tick_lin),
  .src0(src_q[0]), .src1(src_q[1]), .fac0(fac_q[0]), .fac1(fac_q[1])
);

// File: tb/pwm_tick_gen_bench.sv
module pwm_tick_gen_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [0:0] wr_idx = 0;
  logic [3:0] wr_src = 0;
  logic [7:0] wr_div = 0;
  logic [10:0] tick_pre;
  logic [1:0] tick_lin;

  pwm_tick_gen u_pwm_tick_gen (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int t = 0;
  int m_src [2] = '{0, 0};
  int m_fac [2] = '{0, 0};
  int m_sp  [2] = '{0, 0};
  bit done = 0;

  task automatic cycle();
    logic [10:0] ep;
    logic [1:0] el;
    bit wr_i, stick;
    @(negedge clk); #1;
    ep = '0; el = '0;
    if (!rst) begin
      for (int k = 0; k < 11; k++) ep[k] = ((t + 1) % (1 << k)) == 0;
      for (int i = 0; i < 2; i++) begin
        wr_i  = wr_en && (wr_idx == i);
        stick = (m_src[i] < 11) && ep[m_src[i]];
        el[i] = !wr_i && m_fac[i] != 0 && stick && ((m_sp[i] + 1) % m_fac[i] == 0);
      end
    end
    checks++;
    if (tick_pre !== ep) begin
      errors++;
      $display("FAIL %s tick_pre actual %b expected %b t=%0d",
               rst ? "R1" : (wr_en ? "R9" : "R2"), tick_pre, ep, t);
    end
    for (int i = 0; i < 2; i++) begin
      string tag;
      checks++;
      wr_i = wr_en && (wr_idx == i);
      if (rst) tag = "R1";
      else if (wr_i) tag = "R7";
      else if (wr_en) tag = "R8";
      else if (m_fac[i] == 0) tag = "R5";
      else if (m_src[i] > 10) tag = "R6";
      else tag = "R4";
      if (tick_lin[i] !== el[i]) begin
        errors++;
        $display("FAIL %s tick_lin[%0d] actual %b expected %b t=%0d",
                 tag, i, tick_lin[i], el[i], t);
      end
    end
    if (rst) begin
      t = 0;
      for (int i = 0; i < 2; i++) begin m_src[i] = 0; m_fac[i] = 0; m_sp[i] = 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        wr_i  = wr_en && (wr_idx == i);
        stick = (m_src[i] < 11) && ep[m_src[i]];
        if (wr_i) begin
          m_src[i] = int'(wr_src); m_fac[i] = int'(wr_div); m_sp[i] = 0;  // R3
        end else if (stick && m_fac[i] != 0) m_sp[i]++;
      end
      t++;
    end
    @(posedge clk); #1;
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) cycle();
  endtask

  task automatic write(int idx, int src, int fac);
    wr_en = 1; wr_idx = 1'(idx); wr_src = 4'(src); wr_div = 8'(fac);
    cycle();
    wr_en = 0;
  endtask

  initial begin
    rst = 1;
    run(5);                            // R1
    rst = 0;
    run(20);                           // R2, R5 (both off after reset)
    for (int s = 0; s <= 10; s++) begin  // R3, R4
      write(0, s, s % 4 + 1);
      write(1, 10 - s, s % 5 + 1);
      run(1100);
    end
    write(0, 0, 0); run(60);           // R5
    write(0, 12, 1); write(1, 15, 3); run(60);  // R6
    write(0, 0, 255); write(1, 1, 255); run(1200);  // R4 wide factor
    for (int r = 0; r < 80; r++) begin // R7, R8, R9 collisions
      write(r % 2, r % 3, r % 4 + 1);
      run(r % 6);
    end
    write(0, 2, 3); write(1, 0, 2); run(30);
    rst = 1; run(3);                   // R1 mid-run
    rst = 0; run(300);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule